// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block gathers the interrupt sources of a 16550-style serial port and turns them into one interrupt request line and an identification byte that software reads to learn which source needs service. It receives the per-source enables, the receive FIFO fill level and its trigger threshold, a character-timeout flag from the receiver, error events from the receive path, transmit holding status and modem line change events. The FIFOs, the timeout counter and the bus decode are outside the block.

The block holds the state that must survive between bus accesses. It keeps the sticky receive error flags, which clear when the line status byte is read. It keeps the modem change flags, which clear when the modem status byte is read. It keeps the transmit-empty pending flag, which a read of the identification byte consumes. It also presents the line status and modem status bytes, so that software sees the same flags that drive the interrupt.

Top module: `uart_intid`

## Requirements
- R1: After reset the identification byte is 0x01, `irq` is 0, the error bits [4:1] of `line_stat` are 0 and the change bits [3:0] of `modem_stat` are 0.
- R2: Enable bit 0 gates the receive sources, bit 1 transmit-empty, bit 2 line status and bit 3 modem status. A source whose enable is 0 is never reported.
- R3: The line-status source (code 0x6 in bits [3:0]) is reported whenever enable bit 2 is set and any of error flags [4:1] is set. It overrides every other source.
- R4: The receive-data source (code 0x4) is reported when enable bit 0 is set and the fill level is nonzero and at least the trigger in FIFO mode, or nonzero in non-FIFO mode. It disappears in the cycle the level drops below that threshold.
- R5: The character-timeout source (code 0xC) is reported only in FIFO mode, with enable bit 0 set and the timeout flag high, and only when the receive-data source is absent.
- R6: The transmit-empty source (code 0x2) becomes pending one cycle after `thr_empty` rises, or after enable bit 1 rises while `thr_empty` is high. It clears after a read of the identification byte that returned code 0x2, or when `thr_empty` falls.
- R7: The modem source (code 0x0 with bit 0 clear) has the lowest priority and is reported when enable bit 3 is set and any change flag is set.
- R8: Bits [7:6] of the identification byte are both 1 in FIFO mode and both 0 otherwise. Bits [5:4] are always 0.
- R9: `irq` is high exactly when bit 0 of the identification byte is 0.
- R10: `line_stat` holds data-ready in bit 0 (level nonzero), overrun, parity, framing and break in bits 1 to 4, holding-empty in bit 5, transmitter-idle in bit 6, and 0 in bit 7. A line status read clears bits [4:1] on the next cycle. An error event in the same cycle as the read survives.
- R11: `modem_stat` holds change flags in bits [3:0] and the line states in bits [7:4]. A modem status read clears the change flags, and an event in the same cycle survives.
- R12: A read of the identification byte while it reports a source other than transmit-empty leaves a pending transmit-empty source intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_en | input | 4 | Per-source interrupt enables |
| fifo_en | input | 1 | FIFO mode selected |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trigger | input | LVL_W | Receive trigger threshold |
| char_tmo | input | 1 | Character timeout flag from the receiver |
| err_set | input | 4 | Error events: overrun, parity, framing, break |
| thr_empty | input | 1 | Transmit holding register or FIFO empty |
| tx_idle | input | 1 | Transmitter completely empty |
| mchg_set | input | 4 | Modem line change events |
| mline | input | 4 | Current modem line states |
| rd_id | input | 1 | Identification byte is read this cycle |
| rd_line | input | 1 | Line status byte is read this cycle |
| rd_modem | input | 1 | Modem status byte is read this cycle |
| id_byte | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |
| line_stat | output | 8 | Line status byte |
| modem_stat | output | 8 | Modem status byte |

## Verification
A wrong sticky flag shows up in `line_stat` or `modem_stat` in the cycle after the event or read that went wrong. It also shows in `id_byte` and `irq` at once, because the identification is decoded from the flags without a register stage. A wrong transmit-empty pending bit shows as a missing or lingering code 0x2 one cycle after the rise, fall or read that should have changed it. Priority mistakes appear directly as a wrong code when several sources are active together, so the bench drives overlapping sources and checks that the highest-ranked one wins.

// File: rtl/uart_intid_pkg.sv
package uart_intid_pkg;
   // positions inside the enable vector
   localparam int EN_RX  = 0;
   localparam int EN_THR = 1;
   localparam int EN_LS  = 2;
   localparam int EN_MS  = 3;

   // identification codes, bits [3:0] of the identification byte
   localparam logic [3:0] ID_NONE = 4'h1;
   localparam logic [3:0] ID_LS   = 4'h6;
   localparam logic [3:0] ID_RX   = 4'h4;
   localparam logic [3:0] ID_TMO  = 4'hC;
   localparam logic [3:0] ID_THR  = 4'h2;
   localparam logic [3:0] ID_MS   = 4'h0;
endpackage

// File: rtl/uart_intid_sticky.sv
module uart_intid_sticky #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_i,
   output logic [W-1:0] flag_o
);
   if (W < 1) begin : g_bad_w
      $error("uart_intid_sticky: W must be at least 1");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic f_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           f_q <= 1'b0;
         else if (set_i[b])    f_q <= 1'b1;   // new event survives a read
         else if (clr_i)       f_q <= 1'b0;
      end
      assign flag_o[b] = f_q;
   end
endmodule

// File: rtl/uart_intid_thre.sv
module uart_intid_thre (
   input  logic clk,
   input  logic rst_n,
   input  logic empty_i,
   input  logic enable_i,
   input  logic take_i,
   output logic pend_o
);
   logic empty_q, en_q, pend_q;
   logic arm, drop;

   assign arm  = empty_i & (~empty_q | (enable_i & ~en_q));
   assign drop = take_i | ~empty_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
         en_q    <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         empty_q <= empty_i;
         en_q    <= enable_i;
         if (arm)       pend_q <= 1'b1;
         else if (drop) pend_q <= 1'b0;
      end
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/uart_intid_pri.sv
module uart_intid_pri
   import uart_intid_pkg::*;
(
   input  logic       ls_req,
   input  logic       rx_req,
   input  logic       tmo_req,
   input  logic       thr_req,
   input  logic       ms_req,
   output logic [3:0] code_o,
   output logic       is_thr_o
);
   always_comb begin
      is_thr_o = 1'b0;
      if (ls_req)       code_o = ID_LS;
      else if (rx_req)  code_o = ID_RX;
      else if (tmo_req) code_o = ID_TMO;
      else if (thr_req) begin
         code_o   = ID_THR;
         is_thr_o = 1'b1;
      end
      else if (ms_req)  code_o = ID_MS;
      else              code_o = ID_NONE;
   end
endmodule

// File: rtl/uart_intid.sv
module uart_intid
   import uart_intid_pkg::*;
#(
   parameter int LVL_W    = 7,
   parameter bit HAS_FIFO = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       int_en,
   input  logic             fifo_en,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] rx_trigger,
   input  logic             char_tmo,
   input  logic [3:0]       err_set,
   input  logic             thr_empty,
   input  logic             tx_idle,
   input  logic [3:0]       mchg_set,
   input  logic [3:0]       mline,
   input  logic             rd_id,
   input  logic             rd_line,
   input  logic             rd_modem,
   output logic [7:0]       id_byte,
   output logic             irq,
   output logic [7:0]       line_stat,
   output logic [7:0]       modem_stat
);
   if (LVL_W < 2) begin : g_bad_lvl
      $error("uart_intid: LVL_W must be at least 2");
   end

   logic       fifo_on;
   logic [3:0] err_q, chg_q;
   logic       thr_pend, is_thr;
   logic       ls_req, rx_req, tmo_req, thr_req, ms_req;
   logic [3:0] code;
   logic       have_data, at_trig;

   if (HAS_FIFO) begin : g_fifo
      assign fifo_on = fifo_en;
      assign at_trig = fifo_en ? (rx_level >= rx_trigger) : 1'b1;
   end else begin : g_nofifo
      logic unused_fifo;
      assign unused_fifo = fifo_en ^ (|rx_trigger);
      assign fifo_on = 1'b0;
      assign at_trig = 1'b1;
   end

   assign have_data = |rx_level;

   uart_intid_sticky #(.W(4)) u_err (
      .clk(clk), .rst_n(rst_n), .set_i(err_set), .clr_i(rd_line), .flag_o(err_q));

   uart_intid_sticky #(.W(4)) u_chg (
      .clk(clk), .rst_n(rst_n), .set_i(mchg_set), .clr_i(rd_modem), .flag_o(chg_q));

   uart_intid_thre u_thr (
      .clk(clk), .rst_n(rst_n), .empty_i(thr_empty), .enable_i(int_en[EN_THR]),
      .take_i(rd_id & is_thr), .pend_o(thr_pend));

   assign ls_req  = int_en[EN_LS]  & (|err_q);
   assign rx_req  = int_en[EN_RX]  & have_data & at_trig;
   assign tmo_req = int_en[EN_RX]  & fifo_on & char_tmo;
   assign thr_req = int_en[EN_THR] & thr_pend;
   assign ms_req  = int_en[EN_MS]  & (|chg_q);

   uart_intid_pri u_pri (
      .ls_req(ls_req), .rx_req(rx_req), .tmo_req(tmo_req), .thr_req(thr_req),
      .ms_req(ms_req), .code_o(code), .is_thr_o(is_thr));

   assign id_byte    = {{2{fifo_on}}, 2'b00, code};
   assign irq        = ~code[0];
   assign line_stat  = {1'b0, tx_idle, thr_empty, err_q, have_data};
   assign modem_stat = {mline, chg_q};
endmodule

// File: rtl/uart_intid_chk.sv
module uart_intid_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] int_en,
   input logic       fifo_en,
   input logic [3:0] err_set,
   input logic [3:0] mchg_set,
   input logic       thr_empty,
   input logic       rd_id,
   input logic       rd_line,
   input logic       rd_modem,
   input logic [7:0] id_byte,
   input logic [7:0] line_stat,
   input logic [7:0] modem_stat
);
   AST_LS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (int_en[2] && (|line_stat[4:1])) |-> id_byte[3:0] == 4'h6); // R3

   AST_NO_TMO_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |-> !id_byte[3]); // R5

   AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_line && err_set == 4'h0) |=> line_stat[4:1] == 4'h0); // R10

   AST_MODEM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_modem && mchg_set == 4'h0) |=> modem_stat[3:0] == 4'h0); // R11

   AST_THR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_id && id_byte[3:0] == 4'h2 && $past(thr_empty) && $past(int_en[1]))
      |=> id_byte[3:0] != 4'h2); // R6
endmodule

bind uart_intid uart_intid_chk u_chk (
   .clk(clk), .rst_n(rst_n), .int_en(int_en), .fifo_en(fifo_en),
   .err_set(err_set), .mchg_set(mchg_set), .thr_empty(thr_empty),
   .rd_id(rd_id), .rd_line(rd_line), .rd_modem(rd_modem),
   .id_byte(id_byte), .line_stat(line_stat), .modem_stat(modem_stat));

// File: tb/sim_uart_intid.sv
module sim_uart_intid;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] int_en = '0;
   logic       fifo_en = 1'b0;
   logic [6:0] rx_level = '0, rx_trigger = '0;
   logic       char_tmo = 1'b0;
   logic [3:0] err_set = '0, mchg_set = '0, mline = '0;
   logic       thr_empty = 1'b1, tx_idle = 1'b1;
   logic       rd_id = 1'b0, rd_line = 1'b0, rd_modem = 1'b0;
   logic [7:0] id_byte, line_stat, modem_stat;
   logic       irq;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   uart_intid u0 (.*);

   typedef struct packed {
      logic [3:0] en; logic fifo; logic [6:0] lvl; logic [6:0] trig;
      logic tmo; logic [3:0] err; logic [3:0] chg; logic [7:0] exp;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t TAB [NV] = '{
      '{4'hF, 1'b1, 7'd8, 7'd8, 1'b0, 4'h2, 4'h1, 8'hC6},  // R3 all active
      '{4'hF, 1'b1, 7'd8, 7'd8, 1'b0, 4'h0, 4'h1, 8'hC4},  // R4
      '{4'hF, 1'b1, 7'd3, 7'd8, 1'b1, 4'h0, 4'h0, 8'hCC},  // R5
      '{4'hF, 1'b1, 7'd3, 7'd8, 1'b0, 4'h0, 4'h1, 8'hC2},  // R6 over modem
      '{4'h8, 1'b1, 7'd3, 7'd8, 1'b0, 4'h0, 4'h1, 8'hC0},  // R7
      '{4'h0, 1'b1, 7'd8, 7'd8, 1'b1, 4'h2, 4'h1, 8'hC1},  // R2 all masked
      '{4'hB, 1'b1, 7'd8, 7'd8, 1'b0, 4'h4, 4'h0, 8'hC4},  // R2 no LS enable
      '{4'h1, 1'b0, 7'd1, 7'd8, 1'b0, 4'h0, 4'h0, 8'h04},  // R4 plain mode
      '{4'h1, 1'b0, 7'd0, 7'd8, 1'b1, 4'h0, 4'h0, 8'h01},  // R5 plain mode
      '{4'h1, 1'b1, 7'd7, 7'd8, 1'b0, 4'h0, 4'h0, 8'hC1},  // R4 below trig
      '{4'h2, 1'b1, 7'd0, 7'd8, 1'b0, 4'h0, 4'h0, 8'hC2},  // R6
      '{4'h4, 1'b0, 7'd0, 7'd8, 1'b0, 4'h8, 4'h0, 8'h06},  // R8 plain LS
      '{4'h5, 1'b1, 7'd9, 7'd8, 1'b0, 4'h0, 4'h0, 8'hC4}   // R4 above trig
   };

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 id", id_byte, 8'h01);
      chk("R1 irq", {7'd0, irq}, 8'h00);
      chk("R1 line", line_stat, 8'h60);
      chk("R1 modem", modem_stat, 8'h00);

      // table walk
      for (int i = 0; i < NV; i++) begin
         int_en = 4'h0; fifo_en = TAB[i].fifo; rx_level = TAB[i].lvl;
         rx_trigger = TAB[i].trig; char_tmo = TAB[i].tmo;
         err_set = TAB[i].err; mchg_set = TAB[i].chg;
         step();
         err_set = 4'h0; mchg_set = 4'h0; int_en = TAB[i].en;
         step();
         chk("R2-table id", id_byte, TAB[i].exp);
         chk("R9 irq", {7'd0, irq}, {7'd0, ~TAB[i].exp[0]});
         rd_line = 1'b1; rd_modem = 1'b1; int_en = 4'h0;
         step();
         rd_line = 1'b0; rd_modem = 1'b0;
         step();
      end

      // R10 line status layout, clear on read, event wins over read
      fifo_en = 1'b1; rx_level = 7'd2; rx_trigger = 7'd8; char_tmo = 1'b0;
      err_set = 4'b1010; step(); err_set = 4'h0;
      chk("R10 line", line_stat, 8'h75);
      rd_line = 1'b1; step(); rd_line = 1'b0;
      chk("R10 cleared", line_stat, 8'h61);
      err_set = 4'b0001; step();
      rd_line = 1'b1; err_set = 4'b0100; step(); rd_line = 1'b0; err_set = 4'h0;
      chk("R10 set wins", line_stat, 8'h69);
      rd_line = 1'b1; step(); rd_line = 1'b0; rx_level = 7'd0;

      // R11 modem status layout and clearing
      mline = 4'b0101; mchg_set = 4'b0011; step(); mchg_set = 4'h0;
      chk("R11 modem", modem_stat, 8'h53);
      rd_modem = 1'b1; mchg_set = 4'b1000; step(); rd_modem = 1'b0; mchg_set = 4'h0;
      chk("R11 set wins", modem_stat, 8'h58);
      rd_modem = 1'b1; step(); rd_modem = 1'b0;
      chk("R11 cleared", modem_stat, 8'h50);

      // R6 transmit-empty consumed by identification read
      int_en = 4'h0; step(); int_en = 4'h2; step();
      chk("R6 pending", id_byte, 8'hC2);
      rd_id = 1'b1; step(); rd_id = 1'b0;
      chk("R6 read clears", id_byte, 8'hC1);
      thr_empty = 1'b0; step(); thr_empty = 1'b1; step();
      chk("R6 rise re-arms", id_byte, 8'hC2);
      thr_empty = 1'b0; step();
      chk("R6 fall clears", id_byte, 8'hC1);
      thr_empty = 1'b1; step();

      // R12 read while line status shown keeps transmit-empty pending
      int_en = 4'h6; err_set = 4'h2; step(); err_set = 4'h0;
      chk("R12 ls shown", id_byte, 8'hC6);
      rd_id = 1'b1; step(); rd_id = 1'b0;
      rd_line = 1'b1; step(); rd_line = 1'b0;
      chk("R12 thr kept", id_byte, 8'hC2);

      // R4 drop below trigger, R8 mode bits
      int_en = 4'h1; rx_level = 7'd8; step();
      chk("R4 at trig", id_byte, 8'hC4);
      rx_level = 7'd7; #1;
      chk("R4 drop", id_byte, 8'hC1);
      fifo_en = 1'b0; #1;
      chk("R8 plain", id_byte, 8'h04);

      finish_run();
   end
endmodule